// File: doc/BRIEF.md
# Trap and Illegal-Instruction Entry Sequencer

This block runs the hardware part of exception entry for a small 32-bit CPU. The decode stage offers each instruction on a valid/ready interface together with a few classification flags. These flags say whether the instruction is a software trap (with an 8-bit vector number), whether it is undefined code, whether it sits in the delay slot of a delayed branch, and which restricted kinds it belongs to. When the offered instruction must raise an exception, the block accepts it and takes over the pipeline. It raises `busy` to stall the pipeline. It reads the handler address from a vector table, pushes the status word and then the return address onto a descending stack, and finally issues a one-cycle redirect of fetch to the handler. The redirect is not delayed, so no other instruction runs before the handler.

Back-pressure on the decode side works as follows. `dec_ready` is high only while the sequencer is idle. A transfer happens on a clock edge where `dec_valid` and `dec_ready` are both high. While `dec_ready` is low, the decode stage must hold its instruction, and anything driven on the decode inputs is ignored. Instructions that raise nothing pass through in a single handshake with no further effect.

The memory side uses a request/ready handshake. `mem_req` stays high and `mem_addr`, `mem_we` and `mem_wdata` stay unchanged until the memory answers with `mem_ready`. The memory may insert any number of wait cycles.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset `busy`, `mem_req`, `redirect_valid` and `sp_wr_en` are low and `dec_ready` is high.
- R2: When several causes apply to one accepted instruction, a delay-slot violation wins over general illegal code, and general illegal code wins over a trap. Exactly one entry sequence runs per accepted instruction.
- R3: The vector table word address is `vbr_in + 4*vector`. A trap uses `dec_trap_vec`. A delay-slot violation uses parameter `SLOT_VEC` (default 6). General illegal code uses parameter `GEN_VEC` (default 4).
- R4: Each entry makes exactly three memory accesses, in this order: a read of the vector word, then a write of the status word (`sr_in`) at `sp_in-4`, then a write of the return address at `sp_in-8`. After these, the redirect follows.
- R5: For a trap, the stored return address is `dec_pc + INSN_BYTES` (default 2), which is the address of the next instruction.
- R6: A delay-slot violation is raised when `dec_in_slot` is high and the instruction is undefined (`dec_undef`) or has any bit of `dec_slot_kind` set. The bits are: bit0 writes the PC, bit1 is a 32-bit instruction, bit2 is a register-bank restore, bit3 is a signed divide, bit4 is an unsigned divide. Its stored return address is `dec_slot_tgt`, the jump target of the owning branch.
- R7: Undefined code with `dec_in_slot` low raises a general illegal exception that stores `dec_pc`. Outside a slot, `dec_slot_kind` has no effect.
- R8: While `mem_req` is high and `mem_ready` is low, the request, address, write enable and write data are held in the next cycle.
- R9: In the cycle after the last write completes, `redirect_valid` is high for exactly one cycle. In that cycle `redirect_pc` holds the word read from the vector table, and `sp_wr_en` is high with `sp_wr_data = sp_in-8`. In the following cycle `busy` is low.
- R10: `dec_ready` is low while `busy` is high, and decode inputs offered then are ignored. An accepted instruction that raises no exception starts no memory access and does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Decode stage offers an instruction |
| dec_ready | output | 1 | Sequencer idle and able to accept |
| dec_pc | input | 32 | Address of the offered instruction |
| dec_trap | input | 1 | Instruction is a software trap |
| dec_trap_vec | input | 8 | Trap vector number |
| dec_undef | input | 1 | Instruction is undefined code |
| dec_in_slot | input | 1 | Instruction sits in a delay slot |
| dec_slot_tgt | input | 32 | Jump target of the branch owning the slot |
| dec_slot_kind | input | 5 | Restricted-kind flags (see R6) |
| sr_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| vbr_in | input | 32 | Vector table base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the access |
| busy | output | 1 | Entry in progress, pipeline stalled |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | 32 | Handler address |
| sp_wr_en | output | 1 | Stack pointer update strobe |
| sp_wr_data | output | 32 | New stack pointer |

## Verification
The first sweep covers every one of the 256 trap vectors, with the base, stack pointer and memory wait count changing from entry to entry. This shows that the vector index is scaled and added correctly, and that the stack writes land at the two addresses below the stack pointer whatever the latency. A second pattern drives each slot-restricted kind on its own with a trap flag also set. It separates the slot cause from the trap cause by both the vector and the stored target address. Undefined code inside and outside a slot, with the same program counter, tells the slot and general causes apart. A slot with no restricted kind, an ordinary instruction, and decode traffic offered during a busy entry each show that nothing is started.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [4:0] {
    ST_IDLE    = 5'b00001,
    ST_VFETCH  = 5'b00010,
    ST_PUSH_SR = 5'b00100,
    ST_PUSH_PC = 5'b01000,
    ST_JUMP    = 5'b10000
  } seq_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_TRAP = 2'd1,
    CAUSE_GEN  = 2'd2,
    CAUSE_SLOT = 2'd3
  } cause_e;

  localparam int unsigned SLOT_KINDS = 5;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
#(
  parameter int unsigned W          = 32,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned SLOT_VEC   = 6,
  parameter int unsigned GEN_VEC    = 4,
  parameter int unsigned INSN_BYTES = 2
) (
  input  logic                  trap,
  input  logic [VEC_W-1:0]      trap_vec,
  input  logic                  undef,
  input  logic                  in_slot,
  input  logic [SLOT_KINDS-1:0] slot_kind,
  input  logic [W-1:0]          pc,
  input  logic [W-1:0]          slot_tgt,
  output cause_e                cause,
  output logic [VEC_W-1:0]      vec,
  output logic [W-1:0]          ret_pc
);
  localparam logic [VEC_W-1:0] SLOT_V = VEC_W'(SLOT_VEC);
  localparam logic [VEC_W-1:0] GEN_V  = VEC_W'(GEN_VEC);
  localparam logic [W-1:0]     STEP   = W'(INSN_BYTES);

  logic slot_bad;
  logic gen_bad;

  assign slot_bad = in_slot && (undef || (|slot_kind));
  assign gen_bad  = !in_slot && undef;

  // Fixed priority: slot violation, then general illegal, then trap.
  always_comb begin
    cause  = CAUSE_NONE;
    vec    = '0;
    ret_pc = '0;
    if (slot_bad) begin
      cause  = CAUSE_SLOT;
      vec    = SLOT_V;
      ret_pc = slot_tgt;
    end else if (gen_bad) begin
      cause  = CAUSE_GEN;
      vec    = GEN_V;
      ret_pc = pc;
    end else if (trap) begin
      cause  = CAUSE_TRAP;
      vec    = trap_vec;
      ret_pc = pc + STEP;
    end
  end
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mem_ready,
  output seq_state_e state
);
  seq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (start)     nxt = ST_VFETCH;
      ST_VFETCH:  if (mem_ready) nxt = ST_PUSH_SR;
      ST_PUSH_SR: if (mem_ready) nxt = ST_PUSH_PC;
      ST_PUSH_PC: if (mem_ready) nxt = ST_JUMP;
      ST_JUMP:                   nxt = ST_IDLE;
      default:                   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs #(
  parameter int unsigned W     = 32,
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fetch_done,
  input  logic [VEC_W-1:0] vec,
  input  logic [W-1:0]     ret_pc,
  input  logic [W-1:0]     sr,
  input  logic [W-1:0]     sp,
  input  logic [W-1:0]     vbr,
  input  logic [W-1:0]     rdata,
  output logic [W-1:0]     vaddr_q,
  output logic [W-1:0]     sr_q,
  output logic [W-1:0]     slot_sr_q,
  output logic [W-1:0]     slot_pc_q,
  output logic [W-1:0]     ret_pc_q,
  output logic [W-1:0]     handler_q
);
  localparam int unsigned WORD_SHIFT = 2;
  localparam logic [W-1:0] WORD = W'(1 << WORD_SHIFT);

  logic [W-1:0] vec_off;
  assign vec_off = W'(vec) << WORD_SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q   <= '0;
      sr_q      <= '0;
      slot_sr_q <= '0;
      slot_pc_q <= '0;
      ret_pc_q  <= '0;
    end else if (start) begin
      vaddr_q   <= vbr + vec_off;
      sr_q      <= sr;
      slot_sr_q <= sp - WORD;
      slot_pc_q <= sp - (WORD << 1);
      ret_pc_q  <= ret_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          handler_q <= '0;
    else if (fetch_done) handler_q <= rdata;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int unsigned W          = 32,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned SLOT_VEC   = 6,
  parameter int unsigned GEN_VEC    = 4,
  parameter int unsigned INSN_BYTES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dec_valid,
  output logic                  dec_ready,
  input  logic [W-1:0]          dec_pc,
  input  logic                  dec_trap,
  input  logic [VEC_W-1:0]      dec_trap_vec,
  input  logic                  dec_undef,
  input  logic                  dec_in_slot,
  input  logic [W-1:0]          dec_slot_tgt,
  input  logic [SLOT_KINDS-1:0] dec_slot_kind,
  input  logic [W-1:0]          sr_in,
  input  logic [W-1:0]          sp_in,
  input  logic [W-1:0]          vbr_in,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [W-1:0]          mem_addr,
  output logic [W-1:0]          mem_wdata,
  input  logic [W-1:0]          mem_rdata,
  input  logic                  mem_ready,
  output logic                  busy,
  output logic                  redirect_valid,
  output logic [W-1:0]          redirect_pc,
  output logic                  sp_wr_en,
  output logic [W-1:0]          sp_wr_data
);
  cause_e           cause;
  logic [VEC_W-1:0] vec;
  logic [W-1:0]     ret_pc;
  seq_state_e       state;
  logic             start;
  logic [W-1:0]     vaddr_q, sr_q, sr_addr_q, pc_addr_q, ret_pc_q, handler_q;

  exc_classify #(
    .W(W), .VEC_W(VEC_W), .SLOT_VEC(SLOT_VEC),
    .GEN_VEC(GEN_VEC), .INSN_BYTES(INSN_BYTES)
  ) u_cls (
    .trap(dec_trap), .trap_vec(dec_trap_vec), .undef(dec_undef),
    .in_slot(dec_in_slot), .slot_kind(dec_slot_kind), .pc(dec_pc),
    .slot_tgt(dec_slot_tgt), .cause(cause), .vec(vec), .ret_pc(ret_pc)
  );

  assign dec_ready = (state == ST_IDLE);
  assign start     = dec_valid && dec_ready && (cause != CAUSE_NONE);

  exc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_ready(mem_ready), .state(state)
  );

  exc_entry_regs #(.W(W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .start(start),
    .fetch_done((state == ST_VFETCH) && mem_ready),
    .vec(vec), .ret_pc(ret_pc), .sr(sr_in), .sp(sp_in), .vbr(vbr_in),
    .rdata(mem_rdata), .vaddr_q(vaddr_q), .sr_q(sr_q),
    .slot_sr_q(sr_addr_q), .slot_pc_q(pc_addr_q),
    .ret_pc_q(ret_pc_q), .handler_q(handler_q)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_VFETCH: begin
        mem_req  = 1'b1;
        mem_addr = vaddr_q;
      end
      ST_PUSH_SR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sr_addr_q;
        mem_wdata = sr_q;
      end
      ST_PUSH_PC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = pc_addr_q;
        mem_wdata = ret_pc_q;
      end
      default: ;
    endcase
  end

  assign busy           = (state != ST_IDLE);
  assign redirect_valid = (state == ST_JUMP);
  assign redirect_pc    = redirect_valid ? handler_q : '0;
  assign sp_wr_en       = redirect_valid;
  assign sp_wr_data     = redirect_valid ? pc_addr_q : '0;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [4:0]   state,
  input logic         busy,
  input logic         dec_ready,
  input logic         mem_req,
  input logic         mem_we,
  input logic         mem_ready,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         redirect_valid,
  input logic         sp_wr_en
);
  // R4
  state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                 && $stable(mem_we) && $stable(mem_wdata)));

  // R9
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (!redirect_valid && !busy));

  // R9
  redirect_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (sp_wr_en && !mem_req));

  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dec_ready);

  // R4
  req_in_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
endmodule

bind exc_entry_seq exc_entry_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .busy(busy),
  .dec_ready(dec_ready), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .redirect_valid(redirect_valid), .sp_wr_en(sp_wr_en)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0, dec_ready;
  logic [31:0] dec_pc = '0;
  logic        dec_trap = 1'b0;
  logic [7:0]  dec_trap_vec = '0;
  logic        dec_undef = 1'b0, dec_in_slot = 1'b0;
  logic [31:0] dec_slot_tgt = '0;
  logic [4:0]  dec_slot_kind = '0;
  logic [31:0] sr_in = '0, sp_in = '0, vbr_in = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic        busy, redirect_valid, sp_wr_en;
  logic [31:0] redirect_pc, sp_wr_data;

  int tests = 0, fails = 0;
  int wait_cfg = 0, wcnt = 0, nlog = 0;
  logic        log_we   [0:7];
  logic [31:0] log_addr [0:7];
  logic [31:0] log_data [0:7];

  always #10 clk = ~clk;

  exc_entry_seq u_dut (.*);

  function automatic logic [31:0] tbl(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  // Memory model: answers after wait_cfg extra cycles, logs each access.
  always @(negedge clk) begin
    if (mem_req && !mem_ready) begin
      if (wcnt >= wait_cfg) begin
        mem_ready <= 1'b1;
        mem_rdata <= tbl(mem_addr);
        if (nlog < 8) begin
          log_we[nlog]   = mem_we;
          log_addr[nlog] = mem_addr;
          log_data[nlog] = mem_wdata;
        end
        nlog = nlog + 1;
        wcnt = 0;
      end else wcnt = wcnt + 1;
    end else mem_ready <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_dec();
    dec_valid = 0; dec_trap = 0; dec_undef = 0; dec_in_slot = 0;
    dec_slot_kind = '0; dec_trap_vec = '0;
  endtask

  // Offer one instruction; if taken, follow the entry and check it.
  task automatic run_case(input bit trap, input logic [7:0] tv, input bit slot,
                          input bit undef, input logic [4:0] kind,
                          input logic [31:0] pc, input logic [31:0] tgt,
                          input bit taken, input logic [7:0] exp_vec,
                          input logic [31:0] exp_ret, input string req);
    logic [31:0] vaddr, sp;
    int n;
    bit got;
    @(negedge clk);
    vbr_in = 32'h0001_0000 + (tests * 32'h40);
    sp_in  = 32'h0800_0000 - (tests * 32'h10);
    sr_in  = 32'h0000_00F0 ^ tests;
    sp = sp_in;
    vaddr = vbr_in + {22'd0, exp_vec, 2'b00};
    dec_pc = pc; dec_slot_tgt = tgt; dec_trap = trap; dec_trap_vec = tv;
    dec_in_slot = slot; dec_undef = undef; dec_slot_kind = kind;
    dec_valid = 1;
    nlog = 0;
    @(negedge clk);
    if (!taken) begin
      clear_dec();
      @(negedge clk);
      @(negedge clk);
      chk(!busy && nlog == 0 && !redirect_valid, {req, " no entry"}, nlog, 0);
      return;
    end
    chk(busy && !dec_ready, {req, " R10 busy after accept"}, busy, 1);
    // Offer a conflicting trap while busy; it must be ignored.
    dec_trap = 1; dec_trap_vec = ~exp_vec; dec_undef = 0; dec_in_slot = 0;
    got = 0;
    for (int i = 0; i < 80; i++) begin
      if (redirect_valid) begin got = 1; break; end
      @(negedge clk);
    end
    clear_dec();
    chk(got, {req, " R9 redirect seen"}, got, 1);
    chk(redirect_pc == tbl(vaddr), {req, " R3 R9 handler"}, redirect_pc, tbl(vaddr));
    chk(sp_wr_en && sp_wr_data == sp - 8, {req, " R9 sp write"}, sp_wr_data, sp - 8);
    n = nlog;
    chk(n == 3, {req, " R4 access count"}, n, 3);
    if (n == 3) begin
      chk(!log_we[0] && log_addr[0] == vaddr, {req, " R3 vector read"}, log_addr[0], vaddr);
      chk(log_we[1] && log_addr[1] == sp - 4 && log_data[1] == sr_in,
          {req, " R4 sr push"}, log_data[1], sr_in);
      chk(log_we[2] && log_addr[2] == sp - 8 && log_data[2] == exp_ret,
          {req, " R4 pc push"}, log_data[2], exp_ret);
    end
    @(negedge clk);
    chk(!busy && !redirect_valid && dec_ready, {req, " R9 idle after"}, busy, 0);
  endtask

  initial begin
    #5_000_000;
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !mem_req && !redirect_valid && !sp_wr_en && dec_ready,
        "R1 reset state", {busy, mem_req, redirect_valid, sp_wr_en}, 0);
    rst_n = 1;
    // R3 R5: every trap vector, varying wait states
    for (int v = 0; v < 256; v++) begin
      wait_cfg = v % 3;
      run_case(1, v[7:0], 0, 0, 5'd0, 32'h2000 + v * 6, 32'h0,
               1, v[7:0], 32'h2000 + v * 6 + 2, "R5 trap");
    end
    // R6 R2: each slot kind alone plus trap flag
    for (int k = 0; k < 5; k++) begin
      wait_cfg = k % 2;
      run_case(1, 8'h33, 1, 0, 5'(1 << k), 32'h4000 + k * 2, 32'h9000 + k * 16,
               1, 8'd6, 32'h9000 + k * 16, "R6 R2 slot kind");
    end
    run_case(1, 8'h33, 1, 1, 5'd0, 32'h4100, 32'hA000, 1, 8'd6, 32'hA000,
             "R6 R2 slot undef");
    // R7 R2: undefined outside slot, trap and kinds set too
    run_case(1, 8'h33, 0, 1, 5'h1F, 32'h4100, 32'hA000, 1, 8'd4, 32'h4100,
             "R7 R2 general");
    // R2: slot with nothing restricted, trap taken
    run_case(1, 8'h21, 1, 0, 5'd0, 32'h5000, 32'hB000, 1, 8'h21, 32'h5002,
             "R2 trap in slot");
    // R10: plain instructions start nothing
    run_case(0, 8'h00, 1, 0, 5'd0, 32'h6000, 32'hC000, 0, 8'd0, 32'h0,
             "R10 R6 clean slot");
    run_case(0, 8'h00, 0, 0, 5'h1F, 32'h6002, 32'hC000, 0, 8'd0, 32'h0,
             "R10 R7 kinds outside slot");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule